// File: doc/BRIEF.md
# Watchdog Trigger Ownership Controller

This block drives the trigger line of an external watchdog supervisor. From the moment reset is released, it produces a periodic pulse train on its own. By default the period is about 1 ms and each high phase lasts about 507 µs. The supervisor therefore never times out while the FPGA logic is still being configured or is starting up. The supervisor expires somewhere between 0.55 s and 1.65 s without a trigger, and it needs each trigger pulse to stay high for at least 300 ns.

The FPGA logic takes over the trigger by raising an enable input and then toggling a kick input. A kick is counted only on a rising edge seen while the enable is high, and 16 such kicks qualify the FPGA. Ownership then moves at the next boundary of the internal pulse train. From that point the trigger line copies the kick input. Dropping the enable hands the trigger back to the internal generator, which restarts with a full high phase. Both FPGA inputs pass through two-flop synchronizers. All timing constants are derived from a clock-frequency parameter, and shorter values can be set for simulation.

The controller has three states:
- `ST_SELF`: the internal train owns the line.
- `ST_ARMED`: the FPGA is qualified and the block is waiting for the period boundary.
- `ST_FPGA`: the kick input is forwarded to the line.

The transitions are:
- `QUALIFY` (`ST_SELF`→`ST_ARMED`): the enable is high and the count has reached 16.
- `HANDOVER` (`ST_ARMED`→`ST_FPGA`): the last cycle of an internal period.
- `ABORT` (`ST_ARMED`→`ST_SELF`): the enable drops.
- `RECLAIM` (`ST_FPGA`→`ST_SELF`): the enable drops, and the internal train restarts.

Top module: `wdk_handover`

## Requirements
- R1: While `rst_n` is low, `wd_trig_o` is 0. The internal pulse train starts right after reset is released.
- R2: The internal train is high for HIGH_CYC = ceil(HIGH_NS·CLK_HZ/1e9) cycles in every period of PERIOD_CYC = ceil(PERIOD_NS·CLK_HZ/1e9) cycles. By default these are 1 ms and 507 µs.
- R3: Kicks are counted only on rising edges of the synchronized kick input while the synchronized enable is 1. With fewer than QUAL_KICKS (16) kicks counted, the internal train keeps running unchanged.
- R4: Once QUAL_KICKS kicks are counted, ownership passes to the FPGA only after the last cycle of the current internal period. An internal pulse already in progress completes at its full width.
- R5: In FPGA mode, `wd_trig_o` follows `fpga_kick_i` three cycles later with the same high width. No internal pulses appear in this mode.
- R6: The kicks that qualify the FPGA never reach `wd_trig_o`.
- R7: When the enable drops in FPGA mode, the internal train takes the line back and begins with a full HIGH_CYC pulse.
- R8: The kick count clears whenever the enable is low. After a return to internal mode, a fresh run of QUAL_KICKS kicks is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| fpga_wd_en_i | input | 1 | FPGA request to own the trigger (asynchronous) |
| fpga_kick_i | input | 1 | FPGA kick pulses (asynchronous) |
| wd_trig_o | output | 1 | Trigger line to the external supervisor |

## Verification
A wrong kick count or a wrong state shows up at the trigger line within one internal period. Either an expected internal pulse never comes, or an FPGA kick is not forwarded once handover should have happened. A handover taken at the wrong moment shows up as an internal pulse shorter than HIGH_CYC. Leaked qualifying kicks show up as narrow extra pulses. A kick count that does not clear shows up as a missing internal pulse one period after the enable is raised again with only 15 kicks. Every high pulse on the line is measured, so each of these faults fails the width comparison, or the wait for the pulse times out, within about 300 cycles.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef enum logic [1:0] {
        ST_SELF  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FPGA  = 2'd2
    } own_state_t;

    // Rounds a duration in ns up to whole clock cycles.
    function automatic int unsigned ns_to_cycles(longint unsigned hz, longint unsigned ns);
        longint unsigned prod;
        prod = hz * ns;
        return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/wdk_sync.sv
module wdk_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= d_i;
        end
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[i] <= '0;
            end else begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/wdk_pulse_gen.sv
module wdk_pulse_gen #(
    parameter int PERIOD_CYC = 50000,
    parameter int HIGH_CYC   = 25350
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic high_o,
    output logic frame_end_o
);

    localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);
    localparam logic [CW-1:0] HIGH = CW'(HIGH_CYC);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart_i || phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign high_o      = (phase_q < HIGH);
    assign frame_end_o = (phase_q == LAST);

    AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> high_o);                                    // R7
    AST_BOUNDARY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |-> !high_o);                                 // R4
    AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> high_o);                                  // R2

endmodule

// File: rtl/wdk_kick_qual.sv
module wdk_kick_qual #(
    parameter int QUAL_KICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic kick_i,
    output logic qualified_o
);

    localparam int QW = $clog2(QUAL_KICKS + 1);
    localparam logic [QW-1:0] FULL = QW'(QUAL_KICKS);

    logic          kick_d_q;
    logic          kick_rise;
    logic [QW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kick_d_q <= 1'b0;
        end else begin
            kick_d_q <= kick_i;
        end
    end

    assign kick_rise = kick_i && !kick_d_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!en_i) begin
            count_q <= '0;
        end else if (kick_rise && count_q != FULL) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign qualified_o = (count_q == FULL);

    AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !qualified_o);                                  // R8
    AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL);                                         // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !kick_rise) |=> $stable(count_q));               // R3

endmodule

// File: rtl/wdk_handover.sv
module wdk_handover #(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned PERIOD_NS  = 1_000_000,
    parameter int unsigned HIGH_NS    = 507_000,
    parameter int          QUAL_KICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fpga_wd_en_i,
    input  logic fpga_kick_i,
    output logic wd_trig_o
);
    import wdk_pkg::*;

    localparam int PERIOD_CYC = int'(ns_to_cycles(64'(CLK_HZ), 64'(PERIOD_NS)));
    localparam int HIGH_CYC   = int'(ns_to_cycles(64'(CLK_HZ), 64'(HIGH_NS)));

    logic [1:0] sync_q;
    logic       en_s;
    logic       kick_s;
    logic       qualified;
    logic       pg_high;
    logic       pg_frame_end;
    logic       pg_restart;
    own_state_t state_q;
    own_state_t state_d;
    logic       trig_q;

    wdk_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({fpga_wd_en_i, fpga_kick_i}),
        .q_o   (sync_q)
    );
    assign en_s   = sync_q[1];
    assign kick_s = sync_q[0];

    wdk_kick_qual #(.QUAL_KICKS(QUAL_KICKS)) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_s),
        .kick_i      (kick_s),
        .qualified_o (qualified)
    );

    wdk_pulse_gen #(.PERIOD_CYC(PERIOD_CYC), .HIGH_CYC(HIGH_CYC)) u_pgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (pg_restart),
        .high_o      (pg_high),
        .frame_end_o (pg_frame_end)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SELF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: QUALIFY, HANDOVER, ABORT, RECLAIM
    always_comb begin
        state_d    = state_q;
        pg_restart = 1'b0;
        unique case (state_q)
            ST_SELF: begin
                if (en_s && qualified) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!en_s) begin
                    state_d = ST_SELF;
                end else if (pg_frame_end) begin
                    state_d = ST_FPGA;
                end
            end
            ST_FPGA: begin
                if (!en_s) begin
                    state_d    = ST_SELF;
                    pg_restart = 1'b1;
                end
            end
            default: begin
                state_d = ST_SELF;
            end
        endcase
    end

    // Registered output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
        end else if (state_q == ST_FPGA) begin
            trig_q <= kick_s;
        end else begin
            trig_q <= pg_high;
        end
    end

    assign wd_trig_o = trig_q;

    AST_NO_DIRECT_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SELF) |=> (state_q != ST_FPGA));           // R3
    AST_HANDOVER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_FPGA) |-> $past(pg_frame_end));       // R4
    AST_FOLLOW_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FPGA) |=> (wd_trig_o == $past(kick_s)));   // R5
    AST_RECLAIM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q == ST_FPGA) |=> wd_trig_o);                 // R7
    AST_ARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && pg_frame_end) |=> !wd_trig_o);    // R6

endmodule

// File: tb/sim_wdk_handover.sv
`timescale 1ns/1ps
module sim_wdk_handover;

    localparam int HIGH_W   = 50;   // 1000 ns at 50 MHz
    localparam int PERIOD_W = 120;  // 2400 ns at 50 MHz

    typedef struct {
        int    width;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fpga_wd_en = 1'b0;
    logic fpga_kick = 1'b0;
    logic wd_trig;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    wdk_handover #(
        .CLK_HZ(50_000_000), .PERIOD_NS(2400), .HIGH_NS(1000), .QUAL_KICKS(16)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .fpga_wd_en_i(fpga_wd_en),
        .fpga_kick_i(fpga_kick), .wd_trig_o(wd_trig)
    );

    // Monitor: measure every high pulse and compare with the scoreboard
    int hi_len = 0;
    bit mon_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            hi_len   = 0;
            mon_prev = 1'b0;
        end else begin
            if (wd_trig) begin
                hi_len++;
            end else if (mon_prev) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R6/R5: unexpected pulse actual=%0d expected=none", hi_len);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.width != hi_len) begin
                        n_err++;
                        $display("FAIL %s: pulse width actual=%0d expected=%0d", e.req, hi_len, e.width);
                    end
                end
                hi_len = 0;
            end
            mon_prev = wd_trig;
        end
    end

    task automatic push(input int w, input string req);
        exp_t e;
        e.width = w;
        e.req   = req;
        exp_q.push_back(e);
    endtask

    task automatic kick(input int w);
        fpga_kick = 1'b1;
        repeat (w) @(negedge clk);
        fpga_kick = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_edge(input bit rise, input int limit, input string req, output int cyc);
        bit p;
        bit hit;
        p   = wd_trig;
        cyc = 0;
        hit = 1'b0;
        while (!hit && cyc < limit) begin
            @(negedge clk);
            cyc++;
            hit = rise ? (wd_trig && !p) : (!wd_trig && p);
            p   = wd_trig;
        end
        if (!hit) begin
            n_checks++;
            n_err++;
            $display("FAIL %s: edge timeout actual=none expected=edge within %0d", req, limit);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int c;
        // R1: output low in reset
        repeat (4) @(negedge clk);
        n_checks++;
        if (wd_trig !== 1'b0) begin
            n_err++;
            $display("FAIL R1: reset trig actual=%b expected=0", wd_trig);
        end
        push(HIGH_W, "R1"); push(HIGH_W, "R2"); push(HIGH_W, "R2");
        rst_n = 1'b1;
        wait_edge(1'b0, 200, "R1", c);
        wait_edge(1'b0, 200, "R2", c);
        n_checks++;
        if (c != PERIOD_W) begin
            n_err++;
            $display("FAIL R2: period actual=%0d expected=%0d", c, PERIOD_W);
        end
        wait_edge(1'b0, 200, "R2", c);

        // R3: 15 kicks do not hand over
        fpga_wd_en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 15; i++) kick(1);
        push(HIGH_W, "R3");
        wait_edge(1'b0, 300, "R3", c);

        // 16th kick qualifies; R6 kick not forwarded, R5 forwarding
        kick(1);
        repeat (100) @(negedge clk);
        push(7, "R5");
        kick(7);
        wait_edge(1'b0, 50, "R5", c);
        push(12, "R5");
        kick(12);
        wait_edge(1'b0, 50, "R5", c);
        repeat (300) @(negedge clk);  // no internal pulses expected (R5)

        // R7: reclaim restarts with a full pulse
        push(HIGH_W, "R7"); push(HIGH_W, "R7");
        fpga_wd_en = 1'b0;
        wait_edge(1'b0, 300, "R7", c);
        wait_edge(1'b0, 300, "R7", c);

        // R8: count cleared, 15 kicks again insufficient
        fpga_wd_en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 15; i++) kick(1);
        push(HIGH_W, "R8");
        wait_edge(1'b1, 300, "R8", c);
        // R4: qualify mid-pulse, pulse completes at full width
        kick(1);
        wait_edge(1'b0, 100, "R8", c);
        repeat (100) @(negedge clk);
        push(4, "R4");
        kick(4);
        wait_edge(1'b0, 50, "R4", c);
        repeat (20) @(negedge clk);

        n_checks++;
        if (exp_q.size() != 0) begin
            n_err++;
            $display("FAIL R5: pending pulses actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule